// File: doc/BRIEF.md
# Split-Word Ones' Complement Adder

This block is the fixed-point add and subtract stage of a word-oriented processor that keeps its numbers in ones' complement. It works internally by subtraction: the addend is inverted and then subtracted from the first operand, and an end-around borrow folds back inside the lane that produced it. Because of this, a result of zero comes out as positive zero unless both effective inputs are negative zero.

The caller presents two operand pairs, chooses add or add-negative, and picks one of four lane layouts. The first layout is a single 36-bit word. The second is a 72-bit pair, with the high register holding the sign and upper bits and the low register holding the lower 36 bits. The third is two separate 18-bit halves, and the fourth is three separate 12-bit fields. The result is registered one clock after a start strobe and is flagged by a one-cycle valid pulse.

Two sticky designator flops record carry and overflow. They change only on a 36-bit or 72-bit operation, or when the designators are loaded explicitly. Split-word operations leave them as they were.

Top module: `split_oc_adder`

## Requirements
- R1: While rst_n is low, res_hi, res_lo, res_valid, carry_q and ovf_q are all 0.
- R2: A cycle with start high updates res_hi/res_lo at the next rising edge and drives res_valid high for exactly that one cycle. With start low, res_valid is 0 and both result registers keep their value.
- R3: With mode 0 (single word), res_hi is the 36-bit ones' complement a_hi + b_hi when op_neg is 0, or a_hi - b_hi when op_neg is 1. In this mode res_lo is 0.
- R4: A zero result is +0 (all bits clear) unless a and the effective addend (b for add, ~b for add-negative) are both -0 (all ones). So x + (-x) and x - x give +0, while -0 + -0 gives -0.
- R5: With mode 1 (double), {a_hi,a_lo} and {b_hi,b_lo} are 72-bit ones' complement operands with bit 71 as the sign. The result is {res_hi,res_lo}, and the end-around borrow covers all 72 bits.
- R6: With mode 2 (halves), bits 35:18 and 17:0 of the high words form two independent 18-bit lanes, and no borrow crosses between them. res_lo is 0.
- R7: With mode 3 (thirds), bits 35:24, 23:12 and 11:0 of the high words form three independent 12-bit lanes. res_lo is 0.
- R8: After a mode 0 or mode 1 operation, carry_q is 1 exactly when the unsigned first operand is at least the unsigned subtrahend s (s = ~b for add, b for add-negative). That is, carry_q is 1 when the subtraction at the top bit does not borrow.
- R9: After a mode 0 or mode 1 operation, ovf_q is 1 exactly when the first operand and the effective addend have the same sign and the result sign differs from it.
- R10: Mode 2 and mode 3 operations leave carry_q and ovf_q unchanged.
- R11: A cycle with dload high loads carry_q from dload_carry and ovf_q from dload_ovf. A load wins over an arithmetic update in the same cycle. With neither present, the designators hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Perform an operation this cycle |
| op_neg | input | 1 | 0 = add, 1 = add-negative (subtract b) |
| mode | input | 2 | 0 single, 1 double, 2 halves, 3 thirds |
| a_hi | input | 36 | First operand, single word or upper word |
| a_lo | input | 36 | First operand lower word (double only) |
| b_hi | input | 36 | Second operand, single word or upper word |
| b_lo | input | 36 | Second operand lower word (double only) |
| dload | input | 1 | Load the designators explicitly |
| dload_carry | input | 1 | Value loaded into carry_q |
| dload_ovf | input | 1 | Value loaded into ovf_q |
| res_hi | output | 36 | Result, single word or upper word |
| res_lo | output | 36 | Result lower word (double), else 0 |
| res_valid | output | 1 | One-cycle pulse with a new result |
| carry_q | output | 1 | Carry designator |
| ovf_q | output | 1 | Overflow designator |

## Verification
The bench targets the places where a ones' complement adder tends to go wrong. It checks x + (-x) and x - x, where an additive design yields all ones instead of +0. It checks -0 + -0, where a design that forces zero to positive loses the sign. It adds across the 36-bit word boundary in double mode, which a design that wraps the borrow per word would break. It checks split-lane operands in which one lane borrows, where a leaking end-around carry would corrupt the neighbouring lane. It also preloads the designators and then runs split operations and a simultaneous load, so a design that updates the flags on every operation, or lets arithmetic override a load, shows stale or wrong flag values.

// File: rtl/oc_adder_pkg.sv
package oc_adder_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_DOUBLE = 2'd1,
    MODE_HALVES = 2'd2,
    MODE_THIRDS = 2'd3
  } oc_mode_e;

  function automatic logic is_wide_mode(input logic [1:0] m);
    return (oc_mode_e'(m) == MODE_SINGLE) || (oc_mode_e'(m) == MODE_DOUBLE);
  endfunction

endpackage

// File: rtl/ocs_lane.sv
module ocs_lane #(
  parameter int W = 36
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] s,
  output logic [W-1:0] r,
  output logic         no_borrow,
  output logic         ovf
);

  function automatic logic [W:0] sub_raw(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  logic [W:0]   diff;
  logic         eff_sign;

  always_comb begin
    diff      = sub_raw(a, s);
    no_borrow = ~diff[W];
    r         = no_borrow ? diff[W-1:0] : (diff[W-1:0] - {{(W-1){1'b0}}, 1'b1});
    eff_sign  = ~s[W-1];
    ovf       = (a[W-1] == eff_sign) && (r[W-1] != a[W-1]);
  end

endmodule

// File: rtl/oc_split_lanes.sv
module oc_split_lanes #(
  parameter int WORD  = 36,
  parameter int LANES = 2
) (
  input  logic [WORD-1:0]  a,
  input  logic [WORD-1:0]  s,
  output logic [WORD-1:0]  r,
  output logic [LANES-1:0] lane_nb
);

  localparam int LW = WORD / LANES;

  logic [LANES-1:0] lane_ov;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    ocs_lane #(.W(LW)) u_lane (
      .a         (a[i*LW +: LW]),
      .s         (s[i*LW +: LW]),
      .r         (r[i*LW +: LW]),
      .no_borrow (lane_nb[i]),
      .ovf       (lane_ov[i])
    );
  end

  logic unused_ov;
  assign unused_ov = ^lane_ov;

endmodule

// File: rtl/oc_desig_reg.sv
module oc_desig_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_c,
  input  logic load_v,
  input  logic upd,
  input  logic upd_c,
  input  logic upd_v,
  output logic c_q,
  output logic v_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      v_q <= 1'b0;
    end else if (load) begin
      c_q <= load_c;
      v_q <= load_v;
    end else if (upd) begin
      c_q <= upd_c;
      v_q <= upd_v;
    end
  end

endmodule

// File: rtl/split_oc_adder.sv
module split_oc_adder
  import oc_adder_pkg::*;
#(
  parameter int WORD = 36
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_neg,
  input  logic [1:0]      mode,
  input  logic [WORD-1:0] a_hi,
  input  logic [WORD-1:0] a_lo,
  input  logic [WORD-1:0] b_hi,
  input  logic [WORD-1:0] b_lo,
  input  logic            dload,
  input  logic            dload_carry,
  input  logic            dload_ovf,
  output logic [WORD-1:0] res_hi,
  output logic [WORD-1:0] res_lo,
  output logic            res_valid,
  output logic            carry_q,
  output logic            ovf_q
);

  localparam int DW = 2 * WORD;

  // subtrahend: the adder subtracts the negated addend
  logic [WORD-1:0] s_hi, s_lo;
  assign s_hi = op_neg ? b_hi : ~b_hi;
  assign s_lo = op_neg ? b_lo : ~b_lo;

  logic [WORD-1:0] r_single;
  logic            nb_single, ov_single;
  ocs_lane #(.W(WORD)) u_single (
    .a(a_hi), .s(s_hi), .r(r_single), .no_borrow(nb_single), .ovf(ov_single)
  );

  logic [DW-1:0] r_double;
  logic          nb_double, ov_double;
  ocs_lane #(.W(DW)) u_double (
    .a({a_hi, a_lo}), .s({s_hi, s_lo}), .r(r_double),
    .no_borrow(nb_double), .ovf(ov_double)
  );

  logic [WORD-1:0] r_halves, r_thirds;
  logic [1:0]      nb_halves;
  logic [2:0]      nb_thirds;
  oc_split_lanes #(.WORD(WORD), .LANES(2)) u_halves (
    .a(a_hi), .s(s_hi), .r(r_halves), .lane_nb(nb_halves)
  );
  oc_split_lanes #(.WORD(WORD), .LANES(3)) u_thirds (
    .a(a_hi), .s(s_hi), .r(r_thirds), .lane_nb(nb_thirds)
  );

  // named events for the checker
  logic            desig_arith_upd;
  logic            nx_carry, nx_ovf;
  logic [WORD-1:0] nx_hi, nx_lo;

  assign desig_arith_upd = start && is_wide_mode(mode);

  always_comb begin
    nx_hi    = '0;
    nx_lo    = '0;
    nx_carry = 1'b0;
    nx_ovf   = 1'b0;
    unique case (oc_mode_e'(mode))
      MODE_SINGLE: begin
        nx_hi    = r_single;
        nx_carry = nb_single;
        nx_ovf   = ov_single;
      end
      MODE_DOUBLE: begin
        nx_hi    = r_double[DW-1:WORD];
        nx_lo    = r_double[WORD-1:0];
        nx_carry = nb_double;
        nx_ovf   = ov_double;
      end
      MODE_HALVES: nx_hi = r_halves;
      MODE_THIRDS: nx_hi = r_thirds;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hi    <= '0;
      res_lo    <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= start;
      if (start) begin
        res_hi <= nx_hi;
        res_lo <= nx_lo;
      end
    end
  end

  oc_desig_reg u_desig (
    .clk(clk), .rst_n(rst_n),
    .load(dload), .load_c(dload_carry), .load_v(dload_ovf),
    .upd(desig_arith_upd), .upd_c(nx_carry), .upd_v(nx_ovf),
    .c_q(carry_q), .v_q(ovf_q)
  );

  logic unused_nb;
  assign unused_nb = ^{nb_halves, nb_thirds};

endmodule

// File: rtl/split_oc_adder_chk.sv
module split_oc_adder_chk #(
  parameter int WORD = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            op_neg,
  input logic [1:0]      mode,
  input logic [WORD-1:0] a_hi,
  input logic [WORD-1:0] b_hi,
  input logic            dload,
  input logic            dload_carry,
  input logic            dload_ovf,
  input logic [WORD-1:0] res_hi,
  input logic            res_valid,
  input logic            carry_q,
  input logic            ovf_q,
  input logic            desig_arith_upd
);

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> res_valid); // R2
  AST_VALID_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!res_valid && $stable(res_hi))); // R2
  AST_PLUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'd0 && !op_neg && a_hi == ~b_hi) |=> (res_hi == '0)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'd0 && !dload && (a_hi[WORD-1] != (b_hi[WORD-1] ^ op_neg)))
      |=> !ovf_q); // R9
  AST_SPLIT_HOLDS_DESIG: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode[1] && !dload) |=> ($stable(carry_q) && $stable(ovf_q))); // R10
  AST_DLOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dload |=> (carry_q == $past(dload_carry) && ovf_q == $past(dload_ovf))); // R11
  AST_DESIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dload && !desig_arith_upd) |=> ($stable(carry_q) && $stable(ovf_q))); // R11

endmodule

bind split_oc_adder split_oc_adder_chk #(.WORD(WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_neg(op_neg), .mode(mode),
  .a_hi(a_hi), .b_hi(b_hi), .dload(dload), .dload_carry(dload_carry),
  .dload_ovf(dload_ovf), .res_hi(res_hi), .res_valid(res_valid),
  .carry_q(carry_q), .ovf_q(ovf_q), .desig_arith_upd(desig_arith_upd)
);

// File: tb/split_oc_adder_tb.sv
module split_oc_adder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_neg = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [35:0] a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
  logic        dload = 1'b0, dload_carry = 1'b0, dload_ovf = 1'b0;
  logic [35:0] res_hi, res_lo;
  logic        res_valid, carry_q, ovf_q;

  int checks = 0, errors = 0;
  logic exp_c = 1'b0, exp_v = 1'b0;

  always #5 clk = ~clk;

  split_oc_adder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_neg(op_neg), .mode(mode),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
    .dload(dload), .dload_carry(dload_carry), .dload_ovf(dload_ovf),
    .res_hi(res_hi), .res_lo(res_lo), .res_valid(res_valid),
    .carry_q(carry_q), .ovf_q(ovf_q)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // value-based reference: decode both operands to integers, sum, re-encode
  task automatic ref_oc(input int w, input logic [71:0] a, input logic [71:0] b,
                        input logic ng, output logic [71:0] r, output logic c,
                        output logic v);
    logic [71:0] m, aa, s, e, t;
    logic signed [79:0] va, ve, sum, lim, neg;
    m  = (w >= 72) ? {72{1'b1}} : ((72'd1 << w) - 72'd1);
    aa = a & m;
    s  = (ng ? b : ~b) & m;
    e  = (~s) & m;
    c  = (aa >= s);
    t  = (~aa) & m;
    va = aa[w-1] ? -$signed({8'd0, t}) : $signed({8'd0, aa});
    t  = (~e) & m;
    ve = e[w-1] ? -$signed({8'd0, t}) : $signed({8'd0, e});
    sum = va + ve;
    lim = $signed({8'd0, (m >> 1)});
    v  = (sum > lim) || (sum < -lim);
    if (sum == 0) r = (aa == m && e == m) ? m : 72'd0;
    else if (sum > 0) r = sum[71:0];
    else begin
      neg = -sum;
      r = (~neg[71:0]) & m;
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] md, input logic ng,
                        input logic [35:0] ah, input logic [35:0] al,
                        input logic [35:0] bh, input logic [35:0] bl);
    logic [71:0] exp_r, lr;
    logic lc, lv;
    exp_r = '0;
    case (md)
      2'd0: begin
        ref_oc(36, {36'd0, ah}, {36'd0, bh}, ng, lr, lc, lv);
        exp_r = {lr[35:0], 36'd0};
        exp_c = lc; exp_v = lv;
      end
      2'd1: begin
        ref_oc(72, {ah, al}, {bh, bl}, ng, lr, lc, lv);
        exp_r = lr;
        exp_c = lc; exp_v = lv;
      end
      2'd2: for (int i = 0; i < 2; i++) begin
        ref_oc(18, {54'd0, ah[i*18 +: 18]}, {54'd0, bh[i*18 +: 18]}, ng, lr, lc, lv);
        exp_r[36 + i*18 +: 18] = lr[17:0];
      end
      default: for (int i = 0; i < 3; i++) begin
        ref_oc(12, {60'd0, ah[i*12 +: 12]}, {60'd0, bh[i*12 +: 12]}, ng, lr, lc, lv);
        exp_r[36 + i*12 +: 12] = lr[11:0];
      end
    endcase
    @(negedge clk);
    start = 1'b1; mode = md; op_neg = ng;
    a_hi = ah; a_lo = al; b_hi = bh; b_lo = bl;
    @(negedge clk);
    start = 1'b0;
    chk({req, " result"}, {res_hi, res_lo}, exp_r);
    chk({req, " R2 valid"}, {71'd0, res_valid}, 72'd1);
    chk({req, " carry"}, {71'd0, carry_q}, {71'd0, exp_c});
    chk({req, " ovf"}, {71'd0, ovf_q}, {71'd0, exp_v});
  endtask

  task automatic do_dload(input logic c, input logic v);
    @(negedge clk);
    dload = 1'b1; dload_carry = c; dload_ovf = v;
    @(negedge clk);
    dload = 1'b0;
    exp_c = c; exp_v = v;
    chk("R11 dload", {70'd0, carry_q, ovf_q}, {70'd0, c, v});
  endtask

  task automatic t_reset();
    chk("R1 reset", {res_hi, res_lo}, 72'd0);
    chk("R1 reset flags", {69'd0, res_valid, carry_q, ovf_q}, 72'd0);
  endtask

  task automatic t_single();
    run_op("R3 add", 2'd0, 1'b0, 36'd5, 36'd0, 36'd3, 36'd0);
    run_op("R3 sub", 2'd0, 1'b1, 36'd5, 36'd0, 36'd3, 36'd0);
    run_op("R3 neg add", 2'd0, 1'b0, ~36'd5, 36'd0, 36'd3, 36'd0);
    run_op("R8 sub borrow", 2'd0, 1'b1, 36'd3, 36'd0, 36'd9, 36'd0);
  endtask

  task automatic t_zero();
    run_op("R4 x+(-x)", 2'd0, 1'b0, 36'h123456789, 36'd0, ~36'h123456789, 36'd0);
    chk("R4 plus zero", {36'd0, res_hi}, 72'd0);
    run_op("R4 x-x", 2'd0, 1'b1, 36'h0ABCDEF01, 36'd0, 36'h0ABCDEF01, 36'd0);
    run_op("R4 -0+-0", 2'd0, 1'b0, {36{1'b1}}, 36'd0, {36{1'b1}}, 36'd0);
    chk("R4 minus zero", {36'd0, res_hi}, {36'd0, {36{1'b1}}});
  endtask

  task automatic t_overflow();
    run_op("R9 pos ovf", 2'd0, 1'b0, 36'h7FFFFFFFF, 36'd0, 36'd1, 36'd0);
    chk("R9 ovf set", {71'd0, ovf_q}, 72'd1);
    run_op("R9 mixed sign", 2'd0, 1'b0, 36'h7FFFFFFFF, 36'd0, ~36'd4, 36'd0);
  endtask

  task automatic t_double();
    run_op("R5 carry across", 2'd1, 1'b0, 36'd0, {36{1'b1}} >> 1, 36'd0, 36'd1);
    run_op("R5 full low", 2'd1, 1'b0, 36'd0, 36'hFFFFFFFF0, 36'd0, 36'h000000020);
    run_op("R5 borrow across", 2'd1, 1'b1, 36'd1, 36'd0, 36'd0, 36'd1);
    run_op("R5 x+(-x)", 2'd1, 1'b0, 36'd7, 36'd9, ~36'd7, ~36'd9);
    chk("R5 plus zero", {res_hi, res_lo}, 72'd0);
  endtask

  task automatic t_split();
    do_dload(1'b1, 1'b1);
    run_op("R6 halves", 2'd2, 1'b0, {18'd5, 18'h3FFFE}, 36'd0, {18'd3, 18'h3FFFE}, 36'd0);
    chk("R10 halves keep", {70'd0, carry_q, ovf_q}, {70'd0, 2'b11});
    run_op("R6 halves sub", 2'd2, 1'b1, {18'd2, 18'd40}, 36'd0, {18'd7, 18'd1}, 36'd0);
    do_dload(1'b0, 1'b1);
    run_op("R7 thirds", 2'd3, 1'b0, {12'd9, 12'hFFE, 12'd100}, 36'd0,
           {12'hFFD, 12'hFFE, 12'd27}, 36'd0);
    run_op("R7 thirds sub", 2'd3, 1'b1, {12'd1, 12'd50, 12'd0}, 36'd0,
           {12'd2, 12'd50, 12'd3}, 36'd0);
    chk("R10 thirds keep", {70'd0, carry_q, ovf_q}, {70'd0, 2'b01});
  endtask

  task automatic t_dload_prio();
    @(negedge clk);
    start = 1'b1; mode = 2'd0; op_neg = 1'b1; a_hi = 36'd1; b_hi = 36'd5;
    dload = 1'b1; dload_carry = 1'b1; dload_ovf = 1'b1;
    @(negedge clk);
    start = 1'b0; dload = 1'b0;
    chk("R11 priority", {70'd0, carry_q, ovf_q}, {70'd0, 2'b11});
    chk("R3 result beside load", {36'd0, res_hi}, {36'd0, ~36'd4});
    exp_c = 1'b1; exp_v = 1'b1;
  endtask

  task automatic t_idle();
    logic [35:0] held;
    held = res_hi;
    @(negedge clk);
    a_hi = 36'h111; b_hi = 36'h222;
    @(negedge clk);
    chk("R2 valid low", {71'd0, res_valid}, 72'd0);
    chk("R2 result held", {36'd0, res_hi}, {36'd0, held});
    chk("R11 hold", {70'd0, carry_q, ovf_q}, {70'd0, exp_c, exp_v});
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_single();
    t_zero();
    t_overflow();
    t_double();
    t_split();
    t_dload_prio();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule